// File: doc/BRIEF.md
# Flag-Cleared Synchronous RAM

This block wraps a single-port-write, single-port-read synchronous storage array that has no reset and no bulk clear of its own. A one-cycle clear request makes the whole memory read as zero. Each entry carries a stale marker held in flip-flops. A clear sets every marker at once. A read of a marked entry returns zero instead of whatever the array still holds. A write stores the word and removes the marker for that entry.

Two flag organisations can be selected by parameter. The flat form keeps one resettable flag per word. The grouped form keeps one resettable coarse flag per group of words. The per-word flags of each group sit in a resetless array and are only trusted once their group has been touched after a clear. As an option, scrub-on-read writes zero back into a stale entry when it is read, so the array content matches what reads report. Reads have one clock of latency, and leaving reset counts as a clear, so no initialisation pass is needed.

Top module: `flagclr_ram`

## Requirements
- R1: While rst_ni is low, rvalid_o is 0 and rdata_o is 0. After reset is released, every entry reads as zero until it is written, including entries written before the reset.
- R2: A cycle with clear_i high makes every entry read as zero from the following cycle on, until that entry is written again.
- R3: A read takes one cycle. When re_i is high at a rising edge, rvalid_o is 1 and rdata_o carries the result after that edge. When re_i is low at an edge, rvalid_o is 0 and rdata_o keeps its previous value. A read of a stale entry returns all zeros.
- R4: A write with we_i high and clear_i low stores wdata_i at waddr_i. A later read of that address returns the word.
- R5: When clear_i and we_i are high in the same cycle, the clear wins and the written entry reads as zero afterwards.
- R6: A read and a write to the same address in one cycle return the value held before the write, which is zero if the entry was stale.
- R7: In the grouped organisation (address bits above log2(GROUP) select the group), writing one entry of a cleared group leaves every other entry of that group reading zero. Entries of other groups are unaffected.
- R8: With scrub-on-read enabled, a read of a stale entry in a cycle with no write and no clear also writes zero to that address and marks it fresh. Read results are identical to those with scrub disabled.
- R9: A read issued in the same cycle as clear_i returns the value the entry had before the clear.
- R10: The flat and grouped organisations give identical results at the ports for the same stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Mark every entry stale |
| we_i | input | 1 | Write enable |
| waddr_i | input | ADDR_W | Write address |
| wdata_i | input | WIDTH | Write data |
| re_i | input | 1 | Read enable |
| raddr_i | input | ADDR_W | Read address |
| rdata_o | output | WIDTH | Read data, zero for stale entries |
| rvalid_o | output | 1 | Read data valid, one cycle after re_i |

## Verification
Every read result is due exactly one rising edge after the cycle in which re_i, raddr_i and any same-cycle write or clear are presented. The bench drives all inputs at a falling edge and compares rdata_o and rvalid_o at the next falling edge, so each comparison sees the result of exactly one edge. Clear and write updates to the flags take effect at the same edge, so a read in the next cycle already reflects them, and a read in the same cycle still sees the old flags. One instance uses grouped flags without scrubbing and a second uses flat flags with scrubbing. Both are held to the same expected values.

// File: rtl/flagclr_pkg.sv
package flagclr_pkg;
  typedef enum logic {
    FLAG_FLAT    = 1'b0,
    FLAG_GROUPED = 1'b1
  } flag_org_e;
endpackage

// File: rtl/flagclr_store.sv
// Resetless storage array with registered, read-before-write output.
module flagclr_store #(
  parameter int DEPTH  = 256,
  parameter int WIDTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WIDTH-1:0]  rword_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [WIDTH-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rd_q <= mem_q[raddr_i];
  end

  assign rword_o = rd_q;
endmodule

// File: rtl/flagclr_flags.sv
// Stale-flag tracking, flat or two-level.
module flagclr_flags
  import flagclr_pkg::*;
#(
  parameter int        DEPTH    = 256,
  parameter int        GROUP    = 16,
  parameter flag_org_e FLAG_ORG = FLAG_GROUPED,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              mod_en_i,
  input  logic [ADDR_W-1:0] mod_addr_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic              stale_o
);
  generate
    if (FLAG_ORG == FLAG_FLAT) begin : g_flat
      logic [DEPTH-1:0] flag_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       flag_q <= '1;
        else if (clear_i)  flag_q <= '1;
        else if (mod_en_i) flag_q[mod_addr_i] <= 1'b0;
      end

      assign stale_o = flag_q[raddr_i];
    end else begin : g_grouped
      localparam int NGRP   = DEPTH / GROUP;
      localparam int IDX_W  = $clog2(GROUP);

      logic [NGRP-1:0]  coarse_q;
      logic [GROUP-1:0] fine_q [NGRP];
      logic [ADDR_W-IDX_W-1:0] rg, mg;
      logic [IDX_W-1:0]        ri, mi;
      logic [GROUP-1:0]        fine_base, fine_nxt;

      assign rg = raddr_i[ADDR_W-1:IDX_W];
      assign ri = raddr_i[IDX_W-1:0];
      assign mg = mod_addr_i[ADDR_W-1:IDX_W];
      assign mi = mod_addr_i[IDX_W-1:0];

      // an untouched group counts as all-stale, whatever fine_q holds
      assign fine_base = coarse_q[mg] ? '1 : fine_q[mg];
      assign fine_nxt  = fine_base & ~(GROUP'(1) << mi);

      always_ff @(posedge clk_i) begin
        if (mod_en_i) fine_q[mg] <= fine_nxt;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       coarse_q <= '1;
        else if (clear_i)  coarse_q <= '1;
        else if (mod_en_i) coarse_q[mg] <= 1'b0;
      end

      assign stale_o = coarse_q[rg] | fine_q[rg][ri];
    end
  endgenerate
endmodule

// File: rtl/flagclr_ram.sv
module flagclr_ram
  import flagclr_pkg::*;
#(
  parameter int        DEPTH    = 256,
  parameter int        WIDTH    = 16,
  parameter int        GROUP    = 16,
  parameter flag_org_e FLAG_ORG = FLAG_GROUPED,
  parameter bit        SCRUB    = 1'b0,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WIDTH-1:0]  rdata_o,
  output logic              rvalid_o
);
  logic              stale_rd;
  logic              scrub_w;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_waddr;
  logic [WIDTH-1:0]  arr_wdata;
  logic [WIDTH-1:0]  rword;
  logic              stale_q;
  logic              rvalid_q;

  // scrub only takes the write port when the user does not
  assign scrub_w   = SCRUB && re_i && stale_rd && !we_i && !clear_i;
  assign arr_we    = we_i | scrub_w;
  assign arr_waddr = we_i ? waddr_i : raddr_i;
  assign arr_wdata = we_i ? wdata_i : '0;

  flagclr_store #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH)
  ) u_store (
    .clk_i   (clk_i),
    .we_i    (arr_we),
    .waddr_i (arr_waddr),
    .wdata_i (arr_wdata),
    .re_i    (re_i),
    .raddr_i (raddr_i),
    .rword_o (rword)
  );

  flagclr_flags #(
    .DEPTH    (DEPTH),
    .GROUP    (GROUP),
    .FLAG_ORG (FLAG_ORG)
  ) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .mod_en_i   (arr_we),
    .mod_addr_i (arr_waddr),
    .raddr_i    (raddr_i),
    .stale_o    (stale_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stale_q  <= 1'b1;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= re_i;
      if (re_i) stale_q <= stale_rd;
    end
  end

  assign rdata_o  = stale_q ? '0 : rword;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/flagclr_ram_chk.sv
module flagclr_ram_chk #(
  parameter int ADDR_W = 8,
  parameter int WIDTH  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] waddr_i,
  input logic              re_i,
  input logic [ADDR_W-1:0] raddr_i,
  input logic [WIDTH-1:0]  rdata_o,
  input logic              rvalid_o,
  input logic              stale_rd,
  input logic              scrub_w
);
  assert_read_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |=> rvalid_o);

  assert_idle_invalid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> !rvalid_o);

  assert_stale_masked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && stale_rd) |=> (rdata_o == '0));

  assert_clear_all_stale_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> stale_rd);

  assert_write_fresh_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !clear_i) |=> (raddr_i != $past(waddr_i) || !stale_rd));

  assert_scrub_fresh_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scrub_w |=> (raddr_i != $past(raddr_i) || !stale_rd));
endmodule

bind flagclr_ram flagclr_ram_chk #(.ADDR_W(ADDR_W), .WIDTH(WIDTH)) u_chk (.*);

// File: tb/flagclr_ram_tb.sv
module flagclr_ram_tb;
  import flagclr_pkg::*;

  localparam int DEPTH  = 256;
  localparam int WIDTH  = 16;
  localparam int ADDR_W = 8;
  localparam int NVEC   = 14;

  // {clear, we, waddr, wdata, re, raddr, expected rdata}
  localparam logic [50:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'd0,   16'h0000, 1'b1, 8'd5,   16'h0000}, // R1 unwritten
    {1'b0, 1'b1, 8'd5,   16'hA5A5, 1'b1, 8'd5,   16'h0000}, // R6 old stale value
    {1'b0, 1'b0, 8'd0,   16'h0000, 1'b1, 8'd5,   16'hA5A5}, // R4
    {1'b0, 1'b1, 8'd6,   16'h1234, 1'b0, 8'd0,   16'h0000},
    {1'b0, 1'b1, 8'd21,  16'hBEEF, 1'b1, 8'd6,   16'h1234}, // R4
    {1'b0, 1'b0, 8'd0,   16'h0000, 1'b1, 8'd7,   16'h0000}, // R7 neighbour in group
    {1'b1, 1'b0, 8'd0,   16'h0000, 1'b1, 8'd6,   16'h1234}, // R9
    {1'b0, 1'b0, 8'd0,   16'h0000, 1'b1, 8'd6,   16'h0000}, // R2
    {1'b1, 1'b1, 8'd9,   16'h7777, 1'b0, 8'd0,   16'h0000},
    {1'b0, 1'b0, 8'd0,   16'h0000, 1'b1, 8'd9,   16'h0000}, // R5
    {1'b0, 1'b1, 8'd255, 16'hFFFF, 1'b1, 8'd21,  16'h0000}, // R2
    {1'b0, 1'b0, 8'd0,   16'h0000, 1'b1, 8'd255, 16'hFFFF}, // R4 top
    {1'b0, 1'b1, 8'd0,   16'h0001, 1'b1, 8'd255, 16'hFFFF}, // R4
    {1'b0, 1'b0, 8'd0,   16'h0000, 1'b1, 8'd0,   16'h0001}  // R4 bottom
  };

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              clear_i, we_i, re_i;
  logic [ADDR_W-1:0] waddr_i, raddr_i;
  logic [WIDTH-1:0]  wdata_i;
  logic [WIDTH-1:0]  rdata_g, rdata_f;
  logic              rvalid_g, rvalid_f;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  flagclr_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .GROUP(16),
                .FLAG_ORG(FLAG_GROUPED), .SCRUB(1'b0)) u_dut (
    .clk_i, .rst_ni, .clear_i, .we_i, .waddr_i, .wdata_i, .re_i, .raddr_i,
    .rdata_o(rdata_g), .rvalid_o(rvalid_g));

  flagclr_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .GROUP(16),
                .FLAG_ORG(FLAG_FLAT), .SCRUB(1'b1)) u_alt (
    .clk_i, .rst_ni, .clear_i, .we_i, .waddr_i, .wdata_i, .re_i, .raddr_i,
    .rdata_o(rdata_f), .rvalid_o(rvalid_f));

  task automatic chk(input logic ev, input logic [WIDTH-1:0] ed, input string req);
    checks++;
    if (rvalid_g !== ev || rdata_g !== ed) begin
      errors++;
      $display("FAIL %s grouped: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               req, rvalid_g, rdata_g, ev, ed);
    end
    checks++;
    if (rvalid_f !== ev || rdata_f !== ed) begin
      errors++;
      $display("FAIL %s flat-scrub (R8 R10): rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               req, rvalid_f, rdata_f, ev, ed);
    end
  endtask

  task automatic step(input logic c, input logic w, input logic [ADDR_W-1:0] wa,
                      input logic [WIDTH-1:0] wd, input logic r, input logic [ADDR_W-1:0] ra);
    clear_i = c; we_i = w; waddr_i = wa; wdata_i = wd; re_i = r; raddr_i = ra;
    @(negedge clk_i);
  endtask

  function automatic logic [WIDTH-1:0] pat(input int a);
    return WIDTH'(a * 37 + 11);
  endfunction

  initial begin
    rst_ni = 1'b0;
    clear_i = 0; we_i = 0; re_i = 0; waddr_i = '0; raddr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk_i);
    chk(1'b0, '0, "R1 reset state");
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][50], VEC[i][49], VEC[i][48:41], VEC[i][40:25], VEC[i][24], VEC[i][23:16]);
      if (VEC[i][24]) chk(1'b1, VEC[i][15:0], "R3 vector table");
    end

    // idle read: valid drops, data holds
    step(0, 0, '0, '0, 0, '0);
    chk(1'b0, 16'h0001, "R3 idle hold");

    // full sweep
    for (int a = 0; a < DEPTH; a++) step(0, 1, ADDR_W'(a), pat(a), 0, '0);
    for (int a = 0; a < DEPTH; a++) begin
      step(0, 0, '0, '0, 1, ADDR_W'(a));
      chk(1'b1, pat(a), "R4 sweep");
    end
    step(1, 0, '0, '0, 0, '0);
    for (int a = 0; a < DEPTH; a++) begin
      step(0, 0, '0, '0, 1, ADDR_W'(a));
      chk(1'b1, '0, "R2 sweep after clear");
    end

    // repeated stale reads (scrub path) then write still visible
    step(0, 0, '0, '0, 1, 8'd40);
    chk(1'b1, '0, "R8 stale read");
    step(0, 0, '0, '0, 1, 8'd40);
    chk(1'b1, '0, "R8 scrubbed reread");

    // group behaviour after clear
    step(0, 1, 8'd32, 16'hC0DE, 1, 8'd33);
    chk(1'b1, '0, "R7 other entry of group");
    step(0, 0, '0, '0, 1, 8'd33);
    chk(1'b1, '0, "R7 group neighbour stays zero");
    step(0, 0, '0, '0, 1, 8'd32);
    chk(1'b1, 16'hC0DE, "R7 written entry");
    step(0, 1, 8'd50, 16'h5050, 1, 8'd47);
    chk(1'b1, '0, "R7 group boundary low");
    step(0, 0, '0, '0, 1, 8'd48);
    chk(1'b1, '0, "R7 group boundary high");
    step(0, 0, '0, '0, 1, 8'd50);
    chk(1'b1, 16'h5050, "R10 second group");

    // reset mid-run acts as clear
    step(0, 1, 8'd100, 16'h4242, 0, '0);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(1'b0, '0, "R1 reset outputs");
    rst_ni = 1'b1;
    step(0, 0, '0, '0, 1, 8'd100);
    chk(1'b1, '0, "R1 after reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule